// File: doc/BRIEF.md
# Four-Pin GPIO Expander Register Core

This block holds the register state and pin control of a small general-purpose I/O expander. A host reaches it through a plain synchronous register port: a 2-bit register index, a write strobe with write data, and a read strobe whose result appears on a registered read-data bus one clock later. Four registers of one bit per pin are kept: a live input view, an output value register, a polarity mask and a direction register. The direction register decides, pin by pin, whether the block drives the pin or only samples it.

Pin inputs pass through a two-stage synchronizer. The block then compares the synchronized levels of the input-direction pins with a reference snapshot. The snapshot is taken whenever the host reads the input view. On any mismatch, the block enables an open-drain pull-down on its active-low interrupt line. The pull-down lets go when the host reads the input view, or when the pins return to the snapshot. An active-low reset restores every register and the snapshot to their defaults.

Top module: `gpx_core`

## Requirements
- R1: After reset, the output register reads 4'b1111, the polarity mask reads 4'b0000, the direction register reads 4'b1111 (1 = input), `pin_oe` is 4'b0000 and `irq_pull_low` is 0.
- R2: `rd_en` high at a rising edge loads `rd_data` with the register selected by `reg_idx` (0 = input view, 1 = output, 2 = polarity, 3 = direction). `rd_data` keeps that value until the next read.
- R3: `wr_en` high at a rising edge with index 1, 2 or 3 stores `wr_data` in that register from the next cycle. A write to index 0 changes no register.
- R4: For each pin, `pin_oe` is 1 exactly when its direction bit is 0. `pin_out` always carries the output register.
- R5: A read of index 0 returns the synchronized pin levels XOR the polarity mask.
- R6: A pin level applied before a rising edge takes effect in the input view and the interrupt only after two rising edges, and no earlier.
- R7: `irq_pull_low` is 1 while any input-direction pin's synchronized level differs from the reference snapshot. The snapshot resets to all zeros. Polarity does not take part in the comparison.
- R8: A read of index 0 loads the snapshot with the synchronized levels, which releases the interrupt. The interrupt also releases by itself when the pins return to the snapshot.
- R9: Pins whose direction bit is 0 never cause `irq_pull_low`.
- R10: Asserting `rst_n` low at any time returns all registers, the snapshot and `rd_data` to their defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_idx | input | 2 | Register index for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 4 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 4 | Registered read data |
| pin_in | input | 4 | Pin input levels, asynchronous |
| pin_oe | output | 4 | Per-pin drive enable |
| pin_out | output | 4 | Per-pin drive value |
| irq_pull_low | output | 1 | 1 = pull the interrupt line low, 0 = release it |

## Verification
The bench uses the default parameters: four pins, two synchronizer stages, and reset values of all-ones for output and direction and zero for polarity. With four pins, every mixed direction pattern can be reached in a few writes, so input-direction and output-direction pins can be toggled side by side. With two stages, the one-cycle-early and on-time samples of the synchronizer latency fall on neighbouring clock edges that the bench checks one after the other.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

  typedef enum logic [1:0] {
    GPX_IDX_INPUT    = 2'd0,
    GPX_IDX_OUTPUT   = 2'd1,
    GPX_IDX_POLARITY = 2'd2,
    GPX_IDX_CONFIG   = 2'd3
  } gpx_idx_e;

  // Input view seen by the host: raw level flipped where the mask is set.
  function automatic logic [31:0] gpx_view(input logic [31:0] raw, input logic [31:0] mask);
    return raw ^ mask;
  endfunction

  // Pins that are inputs and disagree with the snapshot.
  function automatic logic [31:0] gpx_change(input logic [31:0] live, input logic [31:0] snap,
                                             input logic [31:0] dir_in);
    return (live ^ snap) & dir_in;
  endfunction

endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end

    AST_SYNC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      stage_q[s] == $past(stage_q[s-1])) else $error("sync stage skipped"); // R6
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
  import gpx_pkg::*;
#(
  parameter int             WIDTH   = 4,
  parameter logic [WIDTH-1:0] OUT_RST = '1,
  parameter logic [WIDTH-1:0] POL_RST = '0,
  parameter logic [WIDTH-1:0] CFG_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_idx,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic [WIDTH-1:0] pin_sync,
  output logic [WIDTH-1:0] out_q,
  output logic [WIDTH-1:0] pol_q,
  output logic [WIDTH-1:0] cfg_q,
  output logic [WIDTH-1:0] snap_q,
  output logic [WIDTH-1:0] rd_data,
  output logic             snap_load
);

  gpx_idx_e         idx;
  logic [WIDTH-1:0] view;
  logic [WIDTH-1:0] rd_mux;

  assign idx       = gpx_idx_e'(reg_idx);
  assign view      = WIDTH'(gpx_view(32'(pin_sync), 32'(pol_q)));
  assign snap_load = rd_en && (idx == GPX_IDX_INPUT);

  always_comb begin
    unique case (idx)
      GPX_IDX_INPUT:    rd_mux = view;
      GPX_IDX_OUTPUT:   rd_mux = out_q;
      GPX_IDX_POLARITY: rd_mux = pol_q;
      default:          rd_mux = cfg_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= OUT_RST;
      pol_q <= POL_RST;
      cfg_q <= CFG_RST;
    end else if (wr_en) begin
      case (idx)
        GPX_IDX_OUTPUT:   out_q <= wr_data;
        GPX_IDX_POLARITY: pol_q <= wr_data;
        GPX_IDX_CONFIG:   cfg_q <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      snap_q  <= '0;
    end else if (rd_en) begin
      rd_data <= rd_mux;
      if (snap_load) snap_q <= pin_sync;
    end
  end

  AST_IDX0_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx == 2'd0) |=> ($stable(out_q) && $stable(pol_q) && $stable(cfg_q)))
    else $error("write to input view changed a register"); // R3
  AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)) else $error("read data moved without a read"); // R2
  AST_SNAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    snap_load |=> snap_q == $past(pin_sync)) else $error("snapshot not taken"); // R8

endmodule

// File: rtl/gpx_irq.sv
module gpx_irq
  import gpx_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_sync,
  input  logic [WIDTH-1:0] snap_q,
  input  logic [WIDTH-1:0] cfg_q,
  output logic [WIDTH-1:0] change_mask,
  output logic             irq_pull_low
);

  assign change_mask  = WIDTH'(gpx_change(32'(pin_sync), 32'(snap_q), 32'(cfg_q)));
  assign irq_pull_low = |change_mask;

  AST_IRQ_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pull_low |-> (|cfg_q)) else $error("interrupt with no input pin"); // R9

endmodule

// File: rtl/gpx_core.sv
module gpx_core
  import gpx_pkg::*;
#(
  parameter int               WIDTH       = 4,
  parameter int               SYNC_STAGES = 2,
  parameter logic [WIDTH-1:0] OUT_RST     = '1,
  parameter logic [WIDTH-1:0] POL_RST     = '0,
  parameter logic [WIDTH-1:0] CFG_RST     = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_idx,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] pin_out,
  output logic             irq_pull_low
);

  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] out_q, pol_q, cfg_q, snap_q;
  logic [WIDTH-1:0] change_mask;
  logic             snap_load;

  gpx_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pin_sync)
  );

  gpx_regs #(.WIDTH(WIDTH), .OUT_RST(OUT_RST), .POL_RST(POL_RST), .CFG_RST(CFG_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .pin_sync(pin_sync), .out_q(out_q), .pol_q(pol_q), .cfg_q(cfg_q),
    .snap_q(snap_q), .rd_data(rd_data), .snap_load(snap_load)
  );

  gpx_irq #(.WIDTH(WIDTH)) u_irq (
    .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync), .snap_q(snap_q), .cfg_q(cfg_q),
    .change_mask(change_mask), .irq_pull_low(irq_pull_low)
  );

  assign pin_oe  = ~cfg_q;
  assign pin_out = out_q;

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    snap_load |=> (!irq_pull_low || !$stable(pin_sync) || $changed(cfg_q)))
    else $error("interrupt survived an input read"); // R8
  AST_DRIVEN_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pull_low |-> (|(change_mask & ~pin_oe))) else $error("driven pin raised interrupt"); // R9

endmodule

// File: tb/gpx_core_bench.sv
module gpx_core_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_idx = '0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [3:0] rd_data;
  logic [3:0] pin_in = '0;
  logic [3:0] pin_oe;
  logic [3:0] pin_out;
  logic       irq_pull_low;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpx_core u_gpx_core (
    .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .pin_in(pin_in), .pin_oe(pin_oe),
    .pin_out(pin_out), .irq_pull_low(irq_pull_low)
  );

  // Vector: {is_read, idx[1:0], data[3:0]} ; for reads data is the expected value.
  localparam int NVEC = 11;
  localparam logic [6:0] VEC [NVEC] = '{
    {1'b0, 2'd1, 4'b0101}, {1'b1, 2'd1, 4'b0101},
    {1'b0, 2'd2, 4'b0011}, {1'b1, 2'd2, 4'b0011},
    {1'b0, 2'd3, 4'b1100}, {1'b1, 2'd3, 4'b1100},
    {1'b0, 2'd0, 4'b1010}, {1'b1, 2'd1, 4'b0101},
    {1'b1, 2'd2, 4'b0011}, {1'b1, 2'd3, 4'b1100},
    {1'b1, 2'd1, 4'b0101}
  };

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] idx, input logic [3:0] data);
    @(negedge clk);
    reg_idx = idx; wr_data = data; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] idx, output logic [3:0] val);
    @(negedge clk);
    reg_idx = idx; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    val = rd_data;
  endtask

  task automatic set_pins(input logic [3:0] v);
    @(negedge clk);
    pin_in = v;
  endtask

  task automatic wait_edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [3:0] v;
    wait_edges(3);
    rst_n = 1'b1;
    wait_edges(1);

    // R1 reset state
    check("R1 oe", pin_oe, 4'b0000);
    check("R1 irq", {3'b0, irq_pull_low}, 4'b0000);
    check("R1 pin_out", pin_out, 4'b1111);
    do_read(2'd1, v); check("R1 out", v, 4'b1111);
    do_read(2'd2, v); check("R1 pol", v, 4'b0000);
    do_read(2'd3, v); check("R1 cfg", v, 4'b1111);

    // R2 R3 table walk
    for (int k = 0; k < NVEC; k++) begin
      if (VEC[k][6]) begin
        do_read(VEC[k][5:4], v);
        check("R2/R3 readback", v, VEC[k][3:0]);
      end else begin
        do_write(VEC[k][5:4], VEC[k][3:0]);
      end
    end

    // R2 hold without read
    wait_edges(3);
    check("R2 hold", rd_data, 4'b0101);

    // R4 pins follow cfg 1100 and out 0101
    check("R4 oe", pin_oe, 4'b0011);
    check("R4 out", pin_out, 4'b0101);

    // R5 polarity view: pins 1010, pol 0011
    set_pins(4'b1010);
    wait_edges(2);
    do_read(2'd0, v);
    check("R5 view", v, 4'b1001);

    // R10 reset mid operation
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R10 rd_data", rd_data, 4'b0000);
    check("R10 oe", pin_oe, 4'b0000);
    do_read(2'd2, v); check("R10 pol", v, 4'b0000);
    do_read(2'd1, v); check("R10 out", v, 4'b1111);
    // snapshot reset to zero while pins are 1010 -> interrupt (R7, R10)
    check("R10/R7 snapshot zero", {3'b0, irq_pull_low}, 4'b0001);

    // R8 read clears
    do_read(2'd0, v);
    check("R8 view", v, 4'b1010);
    check("R8 cleared", {3'b0, irq_pull_low}, 4'b0000);

    // R6 latency and R7 assertion
    set_pins(4'b1011);
    wait_edges(1);
    check("R6 early", {3'b0, irq_pull_low}, 4'b0000);
    wait_edges(1);
    check("R6/R7 on time", {3'b0, irq_pull_low}, 4'b0001);

    // R8 self release
    set_pins(4'b1010);
    wait_edges(2);
    check("R8 self release", {3'b0, irq_pull_low}, 4'b0000);

    // R7 polarity has no effect on the comparison
    do_write(2'd2, 4'b1111);
    wait_edges(1);
    check("R7 polarity ignored", {3'b0, irq_pull_low}, 4'b0000);

    // R9 driven pin does not interrupt
    do_write(2'd3, 4'b1110);
    set_pins(4'b1011);
    wait_edges(3);
    check("R9 driven pin", {3'b0, irq_pull_low}, 4'b0000);
    set_pins(4'b0011);
    wait_edges(2);
    check("R9 input pin", {3'b0, irq_pull_low}, 4'b0001);
    do_read(2'd0, v);
    check("R5 inverted view", v, 4'b1100);
    check("R8 cleared again", {3'b0, irq_pull_low}, 4'b0000);

    done = 1'b1;
    finish_run();
  end

endmodule